// File: doc/BRIEF.md
# Quad Double-Buffered DAC Command Controller

This block sits behind a serial front end that has already assembled a 16-bit command word. Each time the front end pulses a strobe, the block decodes the word and updates its state. That state has three parts. First, there are four channels, each with two 12-bit stages: a staging (input) register and an output (DAC) register. Second, there is a sleep flag. Third, there are two single-bit settings: a general-purpose user pin and the edge mode that the serial output stage uses.

The upper four bits of the word select the action. A channel's staging register can be written while its output stays put. A staging write can instead be followed in the same cycle by a transfer of every channel. Other commands transfer all channels, broadcast one value into every register, request sleep, drive the user pin, or pick the output edge mode.

An external permit pin must be high for a sleep request to take effect. A falling edge on that pin while asleep wakes the block with its codes untouched. An asynchronous active-low clear returns everything to its zero state.

Top module: `quad_dac_cmd_ctrl`

## Requirements
- R1: The word is laid out as bits [15:14] channel address, bits [13:12] control, bits [11:0] data. With control 01, the data is written to the addressed channel's staging register and no output register changes.
- R2: With control 11, the data is written to the addressed staging register. In the same cycle, every output register takes its channel's staging value, so the addressed channel receives the new data.
- R3: Opcode bits [15:12] = 0100 copies every staging register into its output register.
- R4: Opcode 1000 writes the data field into all four staging registers and all four output registers.
- R5: Opcode 1100 sets `sleep` when `pdn_allow` (after synchronization) is high. While asleep, output codes are held and staging contents are kept.
- R6: Opcode 1100 has no effect while `pdn_allow` is low.
- R7: Opcode 0010 drives `user_pin` low and opcode 0110 drives it high.
- R8: Opcode 1110 sets `dout_rise_mode` to 1 and opcode 1010 sets it to 0. Both also copy every staging register into its output register.
- R9: A high-to-low change on `pdn_allow` while asleep clears `sleep`, and the output codes keep their pre-sleep values.
- R10: Any command that writes output registers (control 11, opcodes 0100, 1000, 1010 and 1110) clears `sleep`. A control-01 staging write leaves `sleep` unchanged.
- R11: Opcode 0000, or any word presented while `cmd_strobe` is low, changes no register or output.
- R12: While `rst_n` is low, all staging and output codes read zero and `sleep`, `user_pin` and `dout_rise_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| cmd_word | input | 16 | Command word: address, control, data |
| cmd_strobe | input | 1 | One-cycle pulse: execute cmd_word |
| pdn_allow | input | 1 | Sleep permit; falling edge wakes from sleep |
| dac_codes | output | 48 | Four 12-bit output codes, channel 0 in the low bits |
| sleep | output | 1 | Sleep indicator |
| user_pin | output | 1 | General-purpose output level |
| dout_rise_mode | output | 1 | Serial output edge mode, 1 means rising edge |

## Verification
The sleep and wake assertions look at the synchronized permit pin, not the raw one. They therefore assume that `pdn_allow` is an asynchronous level that stays put for several cycles, and that a strobe carries a settled word. The bench changes the permit pin only at a falling clock edge and then waits six cycles before it issues any command that depends on it. The bench pulses `cmd_strobe` for exactly one cycle and never in the cycle a wake edge is expected.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   localparam int OP_W = 4;

   localparam logic [1:0] CTL_STAGE      = 2'b01;
   localparam logic [1:0] CTL_STAGE_XFER = 2'b11;

   localparam logic [OP_W-1:0] OP_IDLE    = 4'b0000;
   localparam logic [OP_W-1:0] OP_USER_LO = 4'b0010;
   localparam logic [OP_W-1:0] OP_XFER    = 4'b0100;
   localparam logic [OP_W-1:0] OP_USER_HI = 4'b0110;
   localparam logic [OP_W-1:0] OP_BCAST   = 4'b1000;
   localparam logic [OP_W-1:0] OP_MODE_FALL = 4'b1010;
   localparam logic [OP_W-1:0] OP_SLEEP   = 4'b1100;
   localparam logic [OP_W-1:0] OP_MODE_RISE = 4'b1110;

   typedef struct packed {
      logic stage_one;
      logic bcast;
      logic xfer_all;
      logic sleep_req;
      logic user_wr;
      logic user_val;
      logic mode_wr;
      logic mode_val;
   } cmd_act_t;

endpackage

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
   import qdac_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 12,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int WORD_W = OP_W + DATA_W
) (
   input  logic [WORD_W-1:0] word,
   input  logic              strobe,
   output cmd_act_t          act,
   output logic [NUM_CH-1:0] stage_sel,
   output logic [DATA_W-1:0] data
);

   logic [OP_W-1:0]   op;
   logic [ADDR_W-1:0] addr;
   logic [1:0]        ctl;

   assign op   = word[WORD_W-1 -: OP_W];
   assign addr = op[OP_W-1 -: ADDR_W];
   assign ctl  = op[1:0];
   assign data = word[DATA_W-1:0];

   always_comb begin
      act = '0;
      if (strobe) begin
         if (ctl == CTL_STAGE || ctl == CTL_STAGE_XFER) begin
            act.stage_one = 1'b1;
            act.xfer_all  = (ctl == CTL_STAGE_XFER);
         end else begin
            unique case (op)
               OP_XFER:      act.xfer_all = 1'b1;
               OP_BCAST:     act.bcast = 1'b1;
               OP_SLEEP:     act.sleep_req = 1'b1;
               OP_USER_LO:   act.user_wr = 1'b1;
               OP_USER_HI: begin
                  act.user_wr  = 1'b1;
                  act.user_val = 1'b1;
               end
               OP_MODE_FALL: begin
                  act.mode_wr  = 1'b1;
                  act.xfer_all = 1'b1;
               end
               OP_MODE_RISE: begin
                  act.mode_wr  = 1'b1;
                  act.mode_val = 1'b1;
                  act.xfer_all = 1'b1;
               end
               default: act = '0;
            endcase
         end
      end
   end

   always_comb begin
      stage_sel = '0;
      if (act.stage_one) stage_sel[addr] = 1'b1;
   end

endmodule

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_level,
   output logic pin_fall
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("qdac_pin_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], pin_async};
         last_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   assign pin_level = chain_q[SYNC_STAGES-1];
   assign pin_fall  = last_q & ~chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 12,
   localparam int FLAT_W = NUM_CH * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] stage_sel,
   input  logic              bcast,
   input  logic              xfer_all,
   input  logic [DATA_W-1:0] data,
   output logic [FLAT_W-1:0] stage_flat,
   output logic [FLAT_W-1:0] out_flat
);

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [DATA_W-1:0] stage_q, out_q, stage_nx;

         always_comb begin
            if (bcast || stage_sel[ch]) stage_nx = data;
            else                        stage_nx = stage_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
               out_q   <= '0;
            end else begin
               stage_q <= stage_nx;
               if (bcast || xfer_all) out_q <= stage_nx;
            end
         end

         assign stage_flat[ch*DATA_W +: DATA_W] = stage_q;
         assign out_flat[ch*DATA_W +: DATA_W]   = out_q;
      end
   endgenerate

   AST_STAGE_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (|stage_sel && !xfer_all && !bcast) |=> $stable(out_flat)); // R1
   AST_XFER_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_all |=> (out_flat == stage_flat)); // R3
   AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      bcast |=> (out_flat == stage_flat)); // R4

endmodule

// File: rtl/quad_dac_cmd_ctrl.sv
module quad_dac_cmd_ctrl
   import qdac_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2,
   localparam int WORD_W = OP_W + DATA_W,
   localparam int FLAT_W = NUM_CH * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] cmd_word,
   input  logic              cmd_strobe,
   input  logic              pdn_allow,
   output logic [FLAT_W-1:0] dac_codes,
   output logic              sleep,
   output logic              user_pin,
   output logic              dout_rise_mode
);

   generate
      if (NUM_CH != 4) begin : g_bad_ch
         $error("quad_dac_cmd_ctrl: address field selects exactly 4 channels");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("quad_dac_cmd_ctrl: DATA_W must be positive");
      end
   endgenerate

   cmd_act_t          act;
   logic [NUM_CH-1:0] stage_sel;
   logic [DATA_W-1:0] data;
   logic [FLAT_W-1:0] stage_flat;
   logic              pdn_level, pdn_fall;
   logic              out_write;

   qdac_cmd_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dec (
      .word(cmd_word), .strobe(cmd_strobe), .act(act),
      .stage_sel(stage_sel), .data(data)
   );

   qdac_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pdn_allow),
      .pin_level(pdn_level), .pin_fall(pdn_fall)
   );

   qdac_chan_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .stage_sel(stage_sel), .bcast(act.bcast),
      .xfer_all(act.xfer_all), .data(data),
      .stage_flat(stage_flat), .out_flat(dac_codes)
   );

   assign out_write = act.bcast | act.xfer_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep          <= 1'b0;
         user_pin       <= 1'b0;
         dout_rise_mode <= 1'b0;
      end else begin
         if (out_write)                        sleep <= 1'b0;
         else if (act.sleep_req && pdn_level)  sleep <= 1'b1;
         else if (sleep && pdn_fall)           sleep <= 1'b0;
         if (act.user_wr) user_pin       <= act.user_val;
         if (act.mode_wr) dout_rise_mode <= act.mode_val;
      end
   end

   AST_SLEEP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (act.sleep_req && !pdn_level && !sleep) |=> !sleep); // R6
   AST_SLEEP_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep) |-> $past(pdn_level)); // R5
   AST_SLEEP_STAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !cmd_strobe) |=> $stable(stage_flat)); // R5
   AST_WAKE_ON_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && pdn_fall && !act.sleep_req) |=> (!sleep && $stable(dac_codes))); // R9
   AST_WRITE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      out_write |=> !sleep); // R10
   AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_strobe || cmd_word[WORD_W-1 -: OP_W] == OP_IDLE)
      |=> ($stable(dac_codes) && $stable(stage_flat) && $stable(user_pin)
           && $stable(dout_rise_mode))); // R11

endmodule

// File: tb/quad_dac_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module quad_dac_cmd_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        cmd_strobe = 1'b0;
   logic        pdn_allow = 1'b0;
   logic [47:0] dac_codes;
   logic        sleep, user_pin, dout_rise_mode;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   quad_dac_cmd_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_strobe(cmd_strobe),
      .pdn_allow(pdn_allow), .dac_codes(dac_codes), .sleep(sleep),
      .user_pin(user_pin), .dout_rise_mode(dout_rise_mode)
   );

   function automatic logic [15:0] mk(input logic [1:0] a, input logic [1:0] c,
                                      input logic [11:0] d);
      return {a, c, d};
   endfunction

   function automatic logic [11:0] code(input int ch);
      return dac_codes[ch*12 +: 12];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w);
      @(negedge clk);
      cmd_word   = w;
      cmd_strobe = 1'b1;
      @(negedge clk);
      cmd_strobe = 1'b0;
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk);
      pdn_allow = v;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 4; i++) chk("R12 reset code", code(i), 0);
      chk("R12 reset sleep", sleep, 0);
      chk("R12 reset user", user_pin, 0);
      chk("R12 reset mode", dout_rise_mode, 0);
   endtask

   task automatic t_stage_then_xfer;
      send(mk(2'd0, 2'b01, 12'h111));
      send(mk(2'd1, 2'b01, 12'h222));
      send(mk(2'd2, 2'b01, 12'h333));
      send(mk(2'd3, 2'b01, 12'h444));
      for (int i = 0; i < 4; i++) chk("R1 stage only", code(i), 0);
      send(mk(2'b01, 2'b00, 12'hFFF));   // opcode 0100
      chk("R3 xfer ch0", code(0), 12'h111);
      chk("R3 xfer ch1", code(1), 12'h222);
      chk("R3 xfer ch2", code(2), 12'h333);
      chk("R3 xfer ch3", code(3), 12'h444);
   endtask

   task automatic t_stage_xfer;
      send(mk(2'd0, 2'b01, 12'h0A0));
      send(mk(2'd2, 2'b11, 12'hC0C));
      chk("R2 ch0 from stage", code(0), 12'h0A0);
      chk("R2 ch1 kept stage", code(1), 12'h222);
      chk("R2 ch2 new data", code(2), 12'hC0C);
      chk("R2 ch3 kept stage", code(3), 12'h444);
   endtask

   task automatic t_bcast;
      send(mk(2'b10, 2'b00, 12'hABC));   // opcode 1000
      for (int i = 0; i < 4; i++) chk("R4 bcast out", code(i), 12'hABC);
      send(mk(2'b01, 2'b00, 12'h000));   // transfer shows staging got it too
      for (int i = 0; i < 4; i++) chk("R4 bcast stage", code(i), 12'hABC);
   endtask

   task automatic t_user;
      send(mk(2'b01, 2'b10, 12'h000));   // 0110
      chk("R7 user high", user_pin, 1);
      send(mk(2'b00, 2'b10, 12'hFFF));   // 0010
      chk("R7 user low", user_pin, 0);
   endtask

   task automatic t_mode;
      send(mk(2'd1, 2'b01, 12'h5A5));
      send(mk(2'b11, 2'b10, 12'h000));   // 1110
      chk("R8 mode rise", dout_rise_mode, 1);
      chk("R8 mode1 xfer", code(1), 12'h5A5);
      send(mk(2'd3, 2'b01, 12'h3C3));
      send(mk(2'b10, 2'b10, 12'h000));   // 1010
      chk("R8 mode fall", dout_rise_mode, 0);
      chk("R8 mode0 xfer", code(3), 12'h3C3);
   endtask

   task automatic t_idle;
      logic [47:0] snap;
      snap = dac_codes;
      send(mk(2'b00, 2'b00, 12'hFFF));   // 0000
      chk("R11 idle codes", dac_codes[31:0], snap[31:0]);
      chk("R11 idle codes hi", {16'h0, dac_codes[47:32]}, {16'h0, snap[47:32]});
      chk("R11 idle user", user_pin, 0);
      @(negedge clk);
      cmd_word = mk(2'b10, 2'b00, 12'h777);  // broadcast with strobe low
      repeat (2) @(negedge clk);
      chk("R11 no strobe", code(0), snap[11:0]);
   endtask

   task automatic t_sleep;
      logic [11:0] c0;
      set_pin(1'b1);
      c0 = code(0);
      send(mk(2'b11, 2'b00, 12'h000));   // 1100
      chk("R5 sleep set", sleep, 1);
      send(mk(2'd0, 2'b01, 12'h9E9));
      chk("R10 stage keeps sleep", sleep, 1);
      chk("R5 out held", code(0), c0);
      send(mk(2'b01, 2'b00, 12'h000));   // 0100 recall
      chk("R10 xfer wakes", sleep, 0);
      chk("R5 stage retained", code(0), 12'h9E9);
      send(mk(2'b11, 2'b00, 12'h000));
      send(mk(2'b10, 2'b00, 12'h123));   // broadcast new data
      chk("R10 bcast wakes", sleep, 0);
   endtask

   task automatic t_locked;
      set_pin(1'b0);
      send(mk(2'b11, 2'b00, 12'h000));
      chk("R6 locked sleep", sleep, 0);
   endtask

   task automatic t_wake;
      logic [11:0] c2;
      set_pin(1'b1);
      send(mk(2'd2, 2'b11, 12'h6B6));
      send(mk(2'b11, 2'b00, 12'h000));
      chk("R9 asleep", sleep, 1);
      c2 = code(2);
      set_pin(1'b0);
      chk("R9 pin wake", sleep, 0);
      chk("R9 code kept", code(2), c2);
   endtask

   task automatic t_clear;
      send(mk(2'b01, 2'b10, 12'h000));
      send(mk(2'b11, 2'b10, 12'h000));
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      for (int i = 0; i < 4; i++) chk("R12 clear code", code(i), 0);
      chk("R12 clear user", user_pin, 0);
      chk("R12 clear mode", dout_rise_mode, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      send(mk(2'b01, 2'b00, 12'h000));
      chk("R12 clear stage", code(1), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stage_then_xfer();
      t_stage_xfer();
      t_bcast();
      t_user();
      t_mode();
      t_idle();
      t_sleep();
      t_locked();
      t_wake();
      t_clear();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule